// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block picks one warp per clock from a fixed pool of eight resident warp slots and reports it to the execution pipeline. Each slot carries a live flag, a thread-block tag and one of four states. The states are Ready, Executing, Waiting and Resident, where Resident means the warp is parked at a block barrier. Switching between warps costs nothing, so a different warp may be picked on every cycle. Selection is round-robin and starts just after the warp that issued last.

For each warp, the decoder presents the head instruction's two source registers, its destination register and a long-latency flag. It may also present a hint for a second instruction with its own two sources and destination. Each warp has a 64-entry scoreboard. Issuing a long-latency head instruction marks its destination as pending, and a writeback completion clears the mark. A warp whose head touches a pending register cannot be picked, and neither can any of its later instructions, because issue within a warp is in order. When the paired instruction is independent of the head, both issue in the same clock.

Barrier arrivals park a warp. Once every live warp of its block is parked, the whole block returns to Ready. Launch and finish events fill and free slots, and a warp never leaves its slot while it lives.

Top module: `wsched_top`

## Requirements
- R1: After reset no slot is live, `issueValid` and `dualIssue` are 0, and `warpLive` is all zeros.
- R2: A launch to a free slot makes it live in state Ready (code 0) after the next edge and records its block tag. A launch to a live slot is ignored and leaves the slot's tag unchanged.
- R3: A finish event frees the slot at the next edge. A freed slot is never selected, even with a valid head.
- R4: A warp is eligible when all of the following hold: it is live, its state is Ready or Executing, its head is valid and its head has no hazard. `issueValid` is raised in the same cycle when any warp is eligible.
- R5: Among eligible warps, selection is round-robin starting at the warp after the last one issued. After reset the search starts at warp 0.
- R6: A warp issued in a cycle shows state Executing (code 1) after the edge that ends it. A live, unblocked warp that was not picked shows Ready.
- R7: Issuing a long-latency head sets the pending bit of its destination register. A head whose source or destination register is pending blocks the warp, and an unpicked blocked warp shows state Waiting (code 2) after the next edge.
- R8: A writeback completion clears its pending bit at the edge that ends its cycle. A Waiting warp whose hazards have cleared shows Ready one edge later and is selectable only from then on.
- R9: `dualIssue` is 1 only when all of the following hold: a warp issues, its pair hint is valid, no pair register is pending, and no pair register equals the head destination.
- R10: A barrier arrival puts the warp in state Resident (code 3) after the next edge. A Resident warp is never selected.
- R11: Once every live warp of a block is Resident, all of them show Ready one edge later. Freeing the last non-arrived warp of the block triggers the same release.
- R12: A writeback clearing one register and a long-latency issue setting another register of the same warp, both in one cycle, each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch a warp into a slot |
| launchWarp | input | 3 | Slot to launch into |
| launchBlock | input | 3 | Block tag of the launched warp |
| finishValid | input | 1 | A warp has completed |
| finishWarp | input | 3 | Slot of the completed warp |
| barrierValid | input | 1 | A warp reached its block barrier |
| barrierWarp | input | 3 | Slot of the arriving warp |
| headValid | input | 8 | Per warp: head instruction present |
| headLong | input | 8 | Per warp: head is long-latency |
| headSrc0 | input | 8x6 | Per warp: head first source register |
| headSrc1 | input | 8x6 | Per warp: head second source register |
| headDst | input | 8x6 | Per warp: head destination register |
| pairValid | input | 8 | Per warp: second instruction hint present |
| pairSrc0 | input | 8x6 | Per warp: pair first source register |
| pairSrc1 | input | 8x6 | Per warp: pair second source register |
| pairDst | input | 8x6 | Per warp: pair destination register |
| wbValid | input | 1 | Long-latency writeback completion |
| wbWarp | input | 3 | Warp of the completion |
| wbReg | input | 6 | Register of the completion |
| issueValid | output | 1 | A warp is selected this cycle |
| issueWarp | output | 3 | Selected warp |
| dualIssue | output | 1 | The pair also issues this cycle |
| warpLive | output | 8 | Per slot live flag |
| warpState | output | 8x2 | Per slot state: 0 Ready, 1 Executing, 2 Waiting, 3 Resident |

## Verification
A writeback completion and a new long-latency issue can both land on the same warp's scoreboard in one cycle. The bench provokes this by issuing a long-latency head to register 20 while a completion clears register 21. It then judges the outcome only through later selection: a head reading register 21 must issue, and a head reading register 20 must be held back. A second collision pits a finish event against a pending barrier. Freeing the one non-arrived warp of a block must release the parked warps exactly one edge later, and the bench samples the states on both sides of that edge.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;
  parameter int unsigned NUM_WARPS = 8;
  parameter int unsigned NUM_REGS  = 64;
  parameter int unsigned BLOCK_W   = 3;
  localparam int unsigned WARP_W     = $clog2(NUM_WARPS);
  localparam int unsigned REG_W      = $clog2(NUM_REGS);
  localparam int unsigned NUM_BLOCKS = 1 << BLOCK_W;

  typedef enum logic [1:0] {
    ST_READY    = 2'd0,
    ST_EXEC     = 2'd1,
    ST_WAIT     = 2'd2,
    ST_RESIDENT = 2'd3
  } warpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              issueEn;
    logic [WARP_W-1:0] issueWarp;
    logic              launchEn;
    logic [WARP_W-1:0] launchWarp;
  } ctlStrobe_t;
endpackage

// File: rtl/wsched_dpath.sv
`timescale 1ns/1ps
module wsched_dpath
  import wsched_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobe_t                       ctl,
  input  logic [NUM_WARPS-1:0]             headLong,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headSrc0,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headSrc1,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headDst,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairSrc0,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairSrc1,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairDst,
  input  logic                             wbValid,
  input  logic [WARP_W-1:0]                wbWarp,
  input  logic [REG_W-1:0]                 wbReg,
  output logic [NUM_WARPS-1:0]             hazard,
  output logic [NUM_WARPS-1:0]             pairOk
);
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] sbQ, sbD;

  always_comb begin
    sbD = sbQ;
    if (wbValid) sbD[wbWarp][wbReg] = 1'b0;
    if (ctl.issueEn && headLong[ctl.issueWarp])
      sbD[ctl.issueWarp][headDst[ctl.issueWarp]] = 1'b1;
    if (ctl.launchEn) sbD[ctl.launchWarp] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sbQ <= '0;
    else       sbQ <= sbD;
  end

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      assign hazard[w] = sbQ[w][headSrc0[w]] | sbQ[w][headSrc1[w]] | sbQ[w][headDst[w]];
      assign pairOk[w] = ~(sbQ[w][pairSrc0[w]] | sbQ[w][pairSrc1[w]] | sbQ[w][pairDst[w]])
                       & (pairSrc0[w] != headDst[w]) & (pairSrc1[w] != headDst[w])
                       & (pairDst[w] != headDst[w]);
    end
  endgenerate

  // R7
  long_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issueEn && headLong[ctl.issueWarp])
    |=> sbQ[$past(ctl.issueWarp)][$past(headDst[ctl.issueWarp])]);

  // R8
  wb_clears_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !(ctl.issueEn && headLong[ctl.issueWarp] && ctl.issueWarp == wbWarp
                  && headDst[ctl.issueWarp] == wbReg))
    |=> !sbQ[$past(wbWarp)][$past(wbReg)]);
endmodule

// File: rtl/wsched_ctrl.sv
`timescale 1ns/1ps
module wsched_ctrl
  import wsched_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         launchValid,
  input  logic [WARP_W-1:0]            launchWarp,
  input  logic [BLOCK_W-1:0]           launchBlock,
  input  logic                         finishValid,
  input  logic [WARP_W-1:0]            finishWarp,
  input  logic                         barrierValid,
  input  logic [WARP_W-1:0]            barrierWarp,
  input  logic [NUM_WARPS-1:0]         headValid,
  input  logic [NUM_WARPS-1:0]         pairValid,
  input  logic [NUM_WARPS-1:0]         hazard,
  input  logic [NUM_WARPS-1:0]         pairOk,
  output ctlStrobe_t                   ctl,
  output logic                         issueValid,
  output logic [WARP_W-1:0]            issueWarp,
  output logic                         dualIssue,
  output logic [NUM_WARPS-1:0]         warpLive,
  output logic [NUM_WARPS-1:0][1:0]    warpState
);
  logic [NUM_WARPS-1:0]              liveQ, liveD;
  logic [NUM_WARPS-1:0][1:0]         stateQ, stateD;
  logic [NUM_WARPS-1:0][BLOCK_W-1:0] blockQ, blockD;
  logic [WARP_W-1:0]                 lastQ;
  logic [NUM_WARPS-1:0]              cand;
  logic [NUM_BLOCKS-1:0]             anyRes, notIn, relBlk;
  logic                              found;
  logic [WARP_W-1:0]                 sel;

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++)
      cand[w] = liveQ[w] && (stateQ[w] == ST_READY || stateQ[w] == ST_EXEC)
                && headValid[w] && !hazard[w];
  end

  // round-robin search from the warp after the last one issued
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      if (!found && cand[WARP_W'((int'(lastQ) + k) % NUM_WARPS)]) begin
        found = 1'b1;
        sel   = WARP_W'((int'(lastQ) + k) % NUM_WARPS);
      end
    end
  end

  always_comb begin
    anyRes = '0;
    notIn  = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (liveQ[w]) begin
        if (stateQ[w] == ST_RESIDENT) anyRes[blockQ[w]] = 1'b1;
        else                          notIn[blockQ[w]]  = 1'b1;
      end
    end
    relBlk = anyRes & ~notIn;
  end

  always_comb begin
    liveD  = liveQ;
    stateD = stateQ;
    blockD = blockQ;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (launchValid && launchWarp == WARP_W'(w) && !liveQ[w]) begin
        liveD[w]  = 1'b1;
        stateD[w] = ST_READY;
        blockD[w] = launchBlock;
      end else if (liveQ[w]) begin
        if (finishValid && finishWarp == WARP_W'(w)) begin
          liveD[w]  = 1'b0;
          stateD[w] = ST_READY;
        end else if (barrierValid && barrierWarp == WARP_W'(w) && stateQ[w] != ST_RESIDENT)
          stateD[w] = ST_RESIDENT;
        else if (stateQ[w] == ST_RESIDENT)
          stateD[w] = relBlk[blockQ[w]] ? ST_READY : ST_RESIDENT;
        else if (found && sel == WARP_W'(w))
          stateD[w] = ST_EXEC;
        else if (headValid[w] && hazard[w])
          stateD[w] = ST_WAIT;
        else
          stateD[w] = ST_READY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ  <= '0;
      stateQ <= '0;
      blockQ <= '0;
      lastQ  <= WARP_W'(NUM_WARPS - 1);
    end else begin
      liveQ  <= liveD;
      stateQ <= stateD;
      blockQ <= blockD;
      if (found) lastQ <= sel;
    end
  end

  assign issueValid     = found;
  assign issueWarp      = sel;
  assign dualIssue      = found & pairValid[sel] & pairOk[sel];
  assign warpLive       = liveQ;
  assign warpState      = stateQ;
  assign ctl.issueEn    = found;
  assign ctl.issueWarp  = sel;
  assign ctl.launchEn   = launchValid && !liveQ[launchWarp];
  assign ctl.launchWarp = launchWarp;

  // R2
  launch_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (launchValid && !liveQ[launchWarp])
    |=> liveQ[$past(launchWarp)] && stateQ[$past(launchWarp)] == ST_READY);

  // R3
  finish_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finishValid && liveQ[finishWarp]) |=> !liveQ[$past(finishWarp)]);

  // R6
  exec_after_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !(barrierValid && barrierWarp == issueWarp)
                && !(finishValid && finishWarp == issueWarp))
    |=> stateQ[$past(issueWarp)] == ST_EXEC);

  // R10
  resident_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> stateQ[issueWarp] != ST_RESIDENT);

  // R9
  dual_needs_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    dualIssue |-> issueValid);
endmodule

// File: rtl/wsched_top.sv
`timescale 1ns/1ps
module wsched_top
  import wsched_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             launchValid,
  input  logic [WARP_W-1:0]                launchWarp,
  input  logic [BLOCK_W-1:0]               launchBlock,
  input  logic                             finishValid,
  input  logic [WARP_W-1:0]                finishWarp,
  input  logic                             barrierValid,
  input  logic [WARP_W-1:0]                barrierWarp,
  input  logic [NUM_WARPS-1:0]             headValid,
  input  logic [NUM_WARPS-1:0]             headLong,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headSrc0,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headSrc1,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  headDst,
  input  logic [NUM_WARPS-1:0]             pairValid,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairSrc0,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairSrc1,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]  pairDst,
  input  logic                             wbValid,
  input  logic [WARP_W-1:0]                wbWarp,
  input  logic [REG_W-1:0]                 wbReg,
  output logic                             issueValid,
  output logic [WARP_W-1:0]                issueWarp,
  output logic                             dualIssue,
  output logic [NUM_WARPS-1:0]             warpLive,
  output logic [NUM_WARPS-1:0][1:0]        warpState
);
  ctlStrobe_t           ctl;
  logic [NUM_WARPS-1:0] hazard, pairOk;

  wsched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchWarp(launchWarp), .launchBlock(launchBlock),
    .finishValid(finishValid), .finishWarp(finishWarp),
    .barrierValid(barrierValid), .barrierWarp(barrierWarp),
    .headValid(headValid), .pairValid(pairValid),
    .hazard(hazard), .pairOk(pairOk), .ctl(ctl),
    .issueValid(issueValid), .issueWarp(issueWarp), .dualIssue(dualIssue),
    .warpLive(warpLive), .warpState(warpState)
  );

  wsched_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .headLong(headLong),
    .headSrc0(headSrc0), .headSrc1(headSrc1), .headDst(headDst),
    .pairSrc0(pairSrc0), .pairSrc1(pairSrc1), .pairDst(pairDst),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .hazard(hazard), .pairOk(pairOk)
  );
endmodule

// File: tb/wsched_top_test.sv
`timescale 1ns/1ps
module wsched_top_test;
  import wsched_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0, finishValid = 1'b0, barrierValid = 1'b0, wbValid = 1'b0;
  logic [WARP_W-1:0] launchWarp = '0, finishWarp = '0, barrierWarp = '0, wbWarp = '0;
  logic [BLOCK_W-1:0] launchBlock = '0;
  logic [REG_W-1:0] wbReg = '0;
  logic [NUM_WARPS-1:0] headValid = '0, headLong = '0, pairValid = '0;
  logic [NUM_WARPS-1:0][REG_W-1:0] headSrc0 = '0, headSrc1 = '0, headDst = '0;
  logic [NUM_WARPS-1:0][REG_W-1:0] pairSrc0 = '0, pairSrc1 = '0, pairDst = '0;
  logic issueValid, dualIssue;
  logic [WARP_W-1:0] issueWarp;
  logic [NUM_WARPS-1:0] warpLive;
  logic [NUM_WARPS-1:0][1:0] warpState;
  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  wsched_top uut (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchWarp(launchWarp), .launchBlock(launchBlock),
    .finishValid(finishValid), .finishWarp(finishWarp),
    .barrierValid(barrierValid), .barrierWarp(barrierWarp),
    .headValid(headValid), .headLong(headLong),
    .headSrc0(headSrc0), .headSrc1(headSrc1), .headDst(headDst),
    .pairValid(pairValid), .pairSrc0(pairSrc0), .pairSrc1(pairSrc1), .pairDst(pairDst),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .issueValid(issueValid), .issueWarp(issueWarp), .dualIssue(dualIssue),
    .warpLive(warpLive), .warpState(warpState)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 issueValid", int'(issueValid), 0);
    chk("R1 dualIssue", int'(dualIssue), 0);
    chk("R1 warpLive", int'(warpLive), 0);

    // R2: launch all slots, block tag = warp / 4
    for (int w = 0; w < NUM_WARPS; w++) begin
      launchValid = 1'b1; launchWarp = WARP_W'(w); launchBlock = BLOCK_W'(w / 4);
      step();
    end
    launchValid = 1'b0;
    chk("R2 all live", int'(warpLive), (1 << NUM_WARPS) - 1);
    for (int w = 0; w < NUM_WARPS; w++) chk("R2 ready after launch", int'(warpState[w]), 0);

    // R5/R6: full round-robin sweep
    headValid = '1;
    settle();
    for (int i = 0; i < 2 * NUM_WARPS; i++) begin
      chk("R5 rr order", int'(issueValid) * 16 + int'(issueWarp), 16 + (i % NUM_WARPS));
      if (i > 0) begin
        chk("R6 issued shows exec", int'(warpState[(i - 1) % NUM_WARPS]), 1);
        chk("R6 other ready", int'(warpState[(i + 1) % NUM_WARPS]), 0);
      end
      step();
    end
    // R5: sparse eligible set {2,5}
    headValid = 8'b0010_0100;
    settle();
    for (int j = 0; j < 4; j++) begin
      chk("R5 sparse rr", int'(issueWarp), (j % 2 == 0) ? 2 : 5);
      step();
    end
    headValid = '0;
    settle();
    chk("R4 no valid head", int'(issueValid), 0);

    // R7/R8: scoreboard on warp 3
    headValid = 8'b0000_1000; headLong[3] = 1'b1; headDst[3] = 6'd10;
    headSrc0[3] = 6'd1; headSrc1[3] = 6'd2;
    settle();
    chk("R4 long head issues", int'(issueValid) * 16 + int'(issueWarp), 16 + 3);
    step();
    headLong[3] = 1'b0; headSrc0[3] = 6'd4; headSrc1[3] = 6'd5; headDst[3] = 6'd10;
    settle();
    chk("R7 write of pending blocks", int'(issueValid), 0);
    chk("R6 exec after issue", int'(warpState[3]), 1);
    step();
    chk("R7 waiting", int'(warpState[3]), 2);
    wbValid = 1'b1; wbWarp = 3'd3; wbReg = 6'd10;
    settle();
    chk("R7 still blocked", int'(issueValid), 0);
    step();
    wbValid = 1'b0;
    settle();
    chk("R8 waiting one more cycle", int'(warpState[3]), 2);
    chk("R8 not yet selectable", int'(issueValid), 0);
    step();
    chk("R8 ready after clear", int'(warpState[3]), 0);
    chk("R8 issues again", int'(issueValid) * 16 + int'(issueWarp), 16 + 3);
    step();

    // R12: same-cycle writeback clear and long issue set
    headLong[3] = 1'b1; headDst[3] = 6'd21; headSrc0[3] = 6'd1; headSrc1[3] = 6'd2;
    settle();
    chk("R12 first long issue", int'(issueValid), 1);
    step();
    headDst[3] = 6'd20;
    wbValid = 1'b1; wbWarp = 3'd3; wbReg = 6'd21;
    settle();
    chk("R12 second long issue", int'(issueValid) * 16 + int'(issueWarp), 16 + 3);
    step();
    wbValid = 1'b0; headLong[3] = 1'b0; headSrc0[3] = 6'd21; headDst[3] = 6'd30;
    settle();
    chk("R12 cleared reg readable", int'(issueValid), 1);
    step();
    headSrc0[3] = 6'd20; headDst[3] = 6'd31;
    settle();
    chk("R12 set reg blocks read", int'(issueValid), 0);
    step();
    headValid = '0; wbValid = 1'b1; wbWarp = 3'd3; wbReg = 6'd20;
    step();
    wbValid = 1'b0;
    step();

    // R9: dual issue on warp 3
    headValid = 8'b0000_1000; headSrc0[3] = 6'd1; headSrc1[3] = 6'd2; headDst[3] = 6'd7;
    pairValid[3] = 1'b1; pairSrc0[3] = 6'd3; pairSrc1[3] = 6'd4; pairDst[3] = 6'd8;
    settle();
    chk("R9 independent pair", int'(dualIssue), 1);
    step();
    pairSrc1[3] = 6'd7;
    settle();
    chk("R9 pair reads head dst", int'(dualIssue), 0);
    step();
    pairSrc1[3] = 6'd4; pairDst[3] = 6'd7;
    settle();
    chk("R9 pair writes head dst", int'(dualIssue), 0);
    step();
    pairDst[3] = 6'd8; pairValid[3] = 1'b0;
    settle();
    chk("R9 no pair hint", int'(dualIssue), 0);
    step();
    pairValid[3] = 1'b1; headLong[3] = 1'b1; headDst[3] = 6'd9;
    settle();
    chk("R9 dual with long head", int'(dualIssue), 1);
    step();
    headLong[3] = 1'b0; headDst[3] = 6'd7; pairSrc0[3] = 6'd9;
    settle();
    chk("R9 pair reads pending", int'(dualIssue) * 2 + int'(issueValid), 1);
    step();
    headValid = '0; pairValid = '0; wbValid = 1'b1; wbWarp = 3'd3; wbReg = 6'd9;
    step();
    wbValid = 1'b0;
    step();

    // R10/R11: barrier for block 1 (warps 4..7)
    for (int w = 4; w < 7; w++) begin
      barrierValid = 1'b1; barrierWarp = WARP_W'(w);
      step();
    end
    barrierValid = 1'b0;
    for (int w = 4; w < 7; w++) chk("R10 resident", int'(warpState[w]), 3);
    chk("R11 not released early", int'(warpState[7]), 0);
    headValid = 8'hF0;
    settle();
    chk("R10 resident skipped", int'(issueValid) * 16 + int'(issueWarp), 16 + 7);
    step();
    headValid = '0; barrierValid = 1'b1; barrierWarp = 3'd7;
    step();
    barrierValid = 1'b0;
    chk("R11 last arrival resident", int'(warpState[7]), 3);
    chk("R11 others still resident", int'(warpState[4]), 3);
    step();
    for (int w = 4; w < 8; w++) chk("R11 block released", int'(warpState[w]), 0);

    // R2: launch to live slot ignored; R3: finish
    launchValid = 1'b1; launchWarp = 3'd1; launchBlock = 3'd5;
    step();
    launchValid = 1'b0;
    chk("R2 ignored launch", int'(warpLive), 8'hFF);
    finishValid = 1'b1; finishWarp = 3'd0;
    step();
    finishValid = 1'b0;
    chk("R3 slot freed", int'(warpLive[0]), 0);
    headValid = 8'h01;
    settle();
    chk("R3 freed never selected", int'(issueValid), 0);
    headValid = '0;

    // R11: block 0 (live 1,2,3); tag of warp 1 must still be 0
    step();
    barrierValid = 1'b1; barrierWarp = 3'd1;
    step();
    barrierValid = 1'b0;
    chk("R10 warp1 resident", int'(warpState[1]), 3);
    step();
    chk("R2 tag kept, no release", int'(warpState[1]), 3);
    barrierValid = 1'b1; barrierWarp = 3'd2;
    step();
    barrierValid = 1'b0; finishValid = 1'b1; finishWarp = 3'd3;
    step();
    finishValid = 1'b0;
    chk("R11 resident before release", int'(warpState[1]), 3);
    step();
    chk("R11 finish releases w1", int'(warpState[1]), 0);
    chk("R11 finish releases w2", int'(warpState[2]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule